// File: doc/BRIEF.md
# Speculative Load Address Checker

This block watches loads that were moved above stores by the scheduler. When such a load executes, the block keeps its byte range and its destination register tag in a small fully associative table. Every store that passes afterwards is compared with all live entries, and any entry whose bytes it touches is dropped. At the load's original place in program order a check operation presents the destination tag. If the entry is still there, the early load was correct. If the entry is gone, the block asks for that destination to be reloaded, and nothing beyond that reload is needed.

The table holds 32 entries by default. Entries come from allocations, are removed by overlapping stores, by the check that consumes them, or by a flush. When the table is full, a round-robin pointer picks the entry to replace. A replaced entry is safe to lose, because its later check simply reports reload.

Top module: `spec_load_guard`

## Requirements
- R1: After reset no entry is live, the response outputs are low, and a check of any tag reports reload.
- R2: `chk_done_o` is high exactly in the cycle after a cycle with `chk_valid_i` high, and low otherwise. A check whose tag has a live entry reports hit.
- R3: A store whose byte range overlaps a live entry's byte range removes that entry. The later check reports reload, and `chk_reload_tag_o` carries the checked tag.
- R4: A store whose byte range only borders an entry's range, directly below or directly above it, leaves the entry live.
- R5: The access size code selects the range length: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes, starting at the given address. Overlap is judged on these ranges, not on address equality.
- R6: A check clears the entry it finds, so a second check of the same tag with no new allocation reports reload.
- R7: An allocation whose tag is already live replaces that entry's address and size. A store to the old range no longer affects it. At most one live entry exists per tag.
- R8: Allocations reuse a same-tag entry first, otherwise the lowest-numbered free entry. With no free entry they replace entries in round-robin order, starting at entry 0 after reset or flush.
- R9: When a store and an allocation of an overlapping range arrive in the same cycle, the allocated entry stays live.
- R10: `flush_i` removes every entry in one cycle. It also resets the round-robin pointer, and it overrides an allocation in the same cycle.
- R11: When `chk_done_o` is high, exactly one of `chk_hit_o` and `chk_reload_o` is high. When it is low, both are low.
- R12: A check sees the table as it stood before any store or allocation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Remove all entries |
| ld_valid_i | input | 1 | Speculative load executed, allocate entry |
| ld_tag_i | input | TAG_W | Destination register tag of the load |
| ld_addr_i | input | ADDR_W | Byte address of the load |
| ld_size_i | input | 2 | Load size code (R5) |
| st_valid_i | input | 1 | Store snoop valid |
| st_addr_i | input | ADDR_W | Byte address of the store |
| st_size_i | input | 2 | Store size code (R5) |
| chk_valid_i | input | 1 | Check operation valid |
| chk_tag_i | input | TAG_W | Tag being checked |
| chk_done_o | output | 1 | Response valid, one cycle after the check |
| chk_hit_o | output | 1 | Speculation held |
| chk_reload_o | output | 1 | Speculation failed, reload needed |
| chk_reload_tag_o | output | TAG_W | Tag of the checked destination |

## Verification
The bench builds the block with DEPTH=8, ADDR_W=16 and TAG_W=5. With these values there are more tags than entries, so a full table can be forced to replace entries round-robin. With the default of 32 entries and 5-bit tags that case cannot be reached, because the same-tag rule always applies first. The narrow address space and a random phase over a 64-byte window make stores hit, border and miss entries often, and they make allocation, store and check collide in the same cycle.

// File: rtl/slg_pkg.sv
package slg_pkg;

   localparam int unsigned SZ_W = 2;

   typedef enum logic [SZ_W-1:0] {
      SZ_B1 = 2'd0,
      SZ_B2 = 2'd1,
      SZ_B4 = 2'd2,
      SZ_B8 = 2'd3
   } acc_size_e;

   // byte count covered by a size code
   function automatic logic [3:0] size_bytes(input logic [SZ_W-1:0] code);
      return 4'd1 << code;
   endfunction

endpackage

// File: rtl/slg_entry.sv
module slg_entry #(
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              wr_i,
   input  logic [TAG_W-1:0]  wr_tag_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [1:0]        wr_size_i,
   input  logic              consume_i,
   input  logic              st_valid_i,
   input  logic [ADDR_W-1:0] st_addr_i,
   input  logic [1:0]        st_size_i,
   output logic              valid_o,
   output logic [TAG_W-1:0]  tag_o
);
   import slg_pkg::*;

   localparam int EXT_W = ADDR_W + 1;

   logic              valid_q;
   logic [TAG_W-1:0]  tag_q;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        size_q;

   logic [EXT_W-1:0]  own_lo, own_hi, st_lo, st_hi;
   logic              st_hit;

   // byte ranges widened by one bit so the end never wraps
   always_comb begin
      own_lo = {1'b0, addr_q};
      own_hi = own_lo + EXT_W'(size_bytes(size_q));
      st_lo  = {1'b0, st_addr_i};
      st_hi  = st_lo + EXT_W'(size_bytes(st_size_i));
      st_hit = valid_q && st_valid_i && (st_lo < own_hi) && (own_lo < st_hi);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else if (flush_i) begin
         valid_q <= 1'b0;
      end else if (wr_i) begin
         valid_q <= 1'b1;
      end else if (consume_i || st_hit) begin
         valid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q  <= '0;
         addr_q <= '0;
         size_q <= '0;
      end else if (wr_i && !flush_i) begin
         tag_q  <= wr_tag_i;
         addr_q <= wr_addr_i;
         size_q <= wr_size_i;
      end
   end

   assign valid_o = valid_q;
   assign tag_o   = tag_q;

endmodule

// File: rtl/slg_pick.sv
module slg_pick #(
   parameter int DEPTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             req_i,
   input  logic [DEPTH-1:0] valid_i,
   input  logic [DEPTH-1:0] same_i,
   output logic [DEPTH-1:0] target_o
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [IDX_W-1:0] rr_q;
   logic [DEPTH-1:0] free_sel, rr_oh;
   logic             any_free, any_same, evict;

   always_comb begin
      free_sel = '0;
      any_free = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!valid_i[i] && !any_free) begin
            free_sel[i] = 1'b1;
            any_free    = 1'b1;
         end
      end
      any_same = |same_i;
      rr_oh    = DEPTH'(1) << rr_q;
      if (any_same)      target_o = same_i;
      else if (any_free) target_o = free_sel;
      else               target_o = rr_oh;
      evict = req_i && !any_same && !any_free;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         rr_q <= '0;
      end else if (evict) begin
         rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
      end
   end

endmodule

// File: rtl/slg_resp.sv
module slg_resp #(
   parameter int TAG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chk_valid_i,
   input  logic             hit_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic             done_o,
   output logic             hit_o,
   output logic             reload_o,
   output logic [TAG_W-1:0] tag_o
);
   logic             done_q, hit_q;
   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         hit_q  <= 1'b0;
         tag_q  <= '0;
      end else begin
         done_q <= chk_valid_i;
         hit_q  <= chk_valid_i && hit_i;
         if (chk_valid_i) tag_q <= tag_i;
      end
   end

   assign done_o   = done_q;
   assign hit_o    = hit_q;
   assign reload_o = done_q && !hit_q;
   assign tag_o    = tag_q;

endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard #(
   parameter int DEPTH  = 32,
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              ld_valid_i,
   input  logic [TAG_W-1:0]  ld_tag_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic [1:0]        ld_size_i,
   input  logic              st_valid_i,
   input  logic [ADDR_W-1:0] st_addr_i,
   input  logic [1:0]        st_size_i,
   input  logic              chk_valid_i,
   input  logic [TAG_W-1:0]  chk_tag_i,
   output logic              chk_done_o,
   output logic              chk_hit_o,
   output logic              chk_reload_o,
   output logic [TAG_W-1:0]  chk_reload_tag_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spec_load_guard: DEPTH must be at least 2");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("spec_load_guard: ADDR_W must be at least 4");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("spec_load_guard: TAG_W must be at least 1");
   end

   logic [DEPTH-1:0] valid_vec, ld_same_vec, chk_match_vec, target_vec, wr_vec;
   logic [TAG_W-1:0] tag_arr [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign ld_same_vec[i]   = valid_vec[i] && (tag_arr[i] == ld_tag_i);
      assign chk_match_vec[i] = valid_vec[i] && (tag_arr[i] == chk_tag_i);
      assign wr_vec[i]        = ld_valid_i && target_vec[i];

      slg_entry #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) i_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush_i   (flush_i),
         .wr_i      (wr_vec[i]),
         .wr_tag_i  (ld_tag_i),
         .wr_addr_i (ld_addr_i),
         .wr_size_i (ld_size_i),
         .consume_i (chk_valid_i && chk_match_vec[i]),
         .st_valid_i(st_valid_i),
         .st_addr_i (st_addr_i),
         .st_size_i (st_size_i),
         .valid_o   (valid_vec[i]),
         .tag_o     (tag_arr[i])
      );
   end

   slg_pick #(.DEPTH(DEPTH)) i_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_i),
      .req_i   (ld_valid_i),
      .valid_i (valid_vec),
      .same_i  (ld_same_vec),
      .target_o(target_vec)
   );

   slg_resp #(.TAG_W(TAG_W)) i_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .chk_valid_i(chk_valid_i),
      .hit_i      (|chk_match_vec),
      .tag_i      (chk_tag_i),
      .done_o     (chk_done_o),
      .hit_o      (chk_hit_o),
      .reload_o   (chk_reload_o),
      .tag_o      (chk_reload_tag_o)
   );

endmodule

// File: rtl/slg_checker.sv
module slg_checker #(
   parameter int DEPTH = 32,
   parameter int TAG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush_i,
   input logic             chk_valid_i,
   input logic [TAG_W-1:0] chk_tag_i,
   input logic             chk_done_o,
   input logic             chk_hit_o,
   input logic             chk_reload_o,
   input logic [TAG_W-1:0] chk_reload_tag_o,
   input logic [DEPTH-1:0] valid_vec,
   input logic [DEPTH-1:0] chk_match_vec
);
   // R2
   chk_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid_i |=> chk_done_o);
   // R2
   chk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid_i |=> !chk_done_o);
   // R11
   resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_done_o |-> (chk_hit_o != chk_reload_o));
   // R11
   resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_done_o |-> (!chk_hit_o && !chk_reload_o));
   // R3
   reload_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid_i |=> (chk_reload_tag_o == $past(chk_tag_i)));
   // R10
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (valid_vec == '0));
   // R7
   tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chk_match_vec));
endmodule

bind spec_load_guard slg_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_slg_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .flush_i         (flush_i),
   .chk_valid_i     (chk_valid_i),
   .chk_tag_i       (chk_tag_i),
   .chk_done_o      (chk_done_o),
   .chk_hit_o       (chk_hit_o),
   .chk_reload_o    (chk_reload_o),
   .chk_reload_tag_o(chk_reload_tag_o),
   .valid_vec       (valid_vec),
   .chk_match_vec   (chk_match_vec)
);

// File: tb/test_spec_load_guard.sv
module test_spec_load_guard;
   localparam int DEPTH  = 8;
   localparam int ADDR_W = 16;
   localparam int TAG_W  = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n, flush_i;
   logic              ld_valid_i, st_valid_i, chk_valid_i;
   logic [TAG_W-1:0]  ld_tag_i, chk_tag_i;
   logic [ADDR_W-1:0] ld_addr_i, st_addr_i;
   logic [1:0]        ld_size_i, st_size_i;
   logic              chk_done_o, chk_hit_o, chk_reload_o;
   logic [TAG_W-1:0]  chk_reload_tag_o;

   spec_load_guard #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) i_spec_load_guard (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .ld_valid_i(ld_valid_i), .ld_tag_i(ld_tag_i), .ld_addr_i(ld_addr_i), .ld_size_i(ld_size_i),
      .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
      .chk_valid_i(chk_valid_i), .chk_tag_i(chk_tag_i),
      .chk_done_o(chk_done_o), .chk_hit_o(chk_hit_o), .chk_reload_o(chk_reload_o),
      .chk_reload_tag_o(chk_reload_tag_o)
   );

   int total = 0;
   int bad   = 0;

   // behavioural reference
   bit     m_v   [DEPTH];
   int     m_tag [DEPTH];
   longint m_lo  [DEPTH];
   longint m_len [DEPTH];
   int     m_rr;
   bit     e_done, e_hit;
   int     e_tag;

   task automatic check_eq(string req, string what, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
      m_rr = 0;
   endtask

   task automatic model_step(bit ld, int ltag, int laddr, int lsz,
                             bit st, int saddr, int ssz, bit ck, int ctag, bit fl);
      bit nv [DEPTH];
      int tgt;
      e_done = ck;
      e_tag  = ctag;
      e_hit  = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (ck && m_v[i] && m_tag[i] == ctag) e_hit = 1'b1;
      if (fl) begin
         model_clear();
         return;
      end
      for (int i = 0; i < DEPTH; i++) begin
         nv[i] = m_v[i];
         if (m_v[i] && ck && m_tag[i] == ctag) nv[i] = 1'b0;
         if (m_v[i] && st && saddr < m_lo[i] + m_len[i] && m_lo[i] < saddr + (1 << ssz))
            nv[i] = 1'b0;
      end
      if (ld) begin
         tgt = -1;
         for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_tag[i] == ltag) tgt = i;
         for (int i = 0; i < DEPTH; i++) if (tgt < 0 && !m_v[i]) tgt = i;
         if (tgt < 0) begin
            tgt  = m_rr;
            m_rr = (m_rr + 1) % DEPTH;
         end
         nv[tgt]    = 1'b1;
         m_tag[tgt] = ltag;
         m_lo[tgt]  = laddr;
         m_len[tgt] = 1 << lsz;
      end
      for (int i = 0; i < DEPTH; i++) m_v[i] = nv[i];
   endtask

   task automatic idle_inputs();
      flush_i = 0; ld_valid_i = 0; st_valid_i = 0; chk_valid_i = 0;
      ld_tag_i = '0; chk_tag_i = '0; ld_addr_i = '0; st_addr_i = '0;
      ld_size_i = '0; st_size_i = '0;
   endtask

   // one cycle: drive at negedge, compare at the following negedge
   task automatic step(string req, bit ld, int ltag, int laddr, int lsz,
                       bit st, int saddr, int ssz, bit ck, int ctag, bit fl);
      ld_valid_i = ld;  ld_tag_i = TAG_W'(ltag); ld_addr_i = ADDR_W'(laddr); ld_size_i = 2'(lsz);
      st_valid_i = st;  st_addr_i = ADDR_W'(saddr); st_size_i = 2'(ssz);
      chk_valid_i = ck; chk_tag_i = TAG_W'(ctag);
      flush_i = fl;
      model_step(ld, ltag, laddr, lsz, st, saddr, ssz, ck, ctag, fl);
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      check_eq(req, "done", chk_done_o, e_done);
      check_eq(req, "hit", chk_hit_o, e_hit);
      check_eq(req, "reload", chk_reload_o, e_done && !e_hit);
      if (e_done) check_eq(req, "reload_tag", chk_reload_tag_o, e_tag);
   endtask

   task automatic alloc(string req, int tag, int addr, int sz);
      step(req, 1, tag, addr, sz, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic store(string req, int addr, int sz);
      step(req, 0, 0, 0, 0, 1, addr, sz, 0, 0, 0);
   endtask
   task automatic check(string req, int tag, int exp_hit);
      step(req, 0, 0, 0, 0, 0, 0, 0, 1, tag, 0);
      check_eq(req, "literal hit", chk_hit_o, exp_hit);
   endtask
   task automatic flush(string req);
      step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check_eq("R1", "done after reset", chk_done_o, 0);
      check_eq("R1", "reload after reset", chk_reload_o, 0);
      check("R1", 3, 0);

      // R2 hit and R6 consume
      alloc("R2", 1, 'h100, 2);
      check("R2", 1, 1);
      check("R6", 1, 0);

      // R3 overlapping store at last byte of an 8-byte entry
      alloc("R3", 2, 'h200, 3);
      store("R3", 'h207, 0);
      check("R3", 2, 0);
      check_eq("R3", "tag", chk_reload_tag_o, 2);

      // R4 bordering stores above and below
      alloc("R4", 4, 'h300, 2);
      store("R4", 'h304, 2);
      store("R4", 'h2FC, 2);
      check("R4", 4, 1);

      // R5 sizes: 4-byte store covers 2-byte entry at offset 2; 8-byte store ends before 1-byte entry
      alloc("R5", 5, 'h402, 1);
      store("R5", 'h400, 2);
      check("R5", 5, 0);
      alloc("R5", 6, 'h410, 0);
      store("R5", 'h408, 3);
      check("R5", 6, 1);

      // R7 same-tag overwrite
      alloc("R7", 7, 'h500, 2);
      alloc("R7", 7, 'h600, 2);
      store("R7", 'h500, 2);
      check("R7", 7, 1);
      alloc("R7", 7, 'h500, 2);
      alloc("R7", 7, 'h600, 2);
      store("R7", 'h600, 2);
      check("R7", 7, 0);

      // R9 store and allocation collide
      step("R9", 1, 8, 'h700, 2, 1, 'h700, 2, 0, 0, 0);
      check("R9", 8, 1);

      // R12 check sees the table before a same-cycle allocation
      step("R12", 1, 9, 'h800, 2, 0, 0, 0, 1, 9, 0);
      check_eq("R12", "literal hit", chk_hit_o, 0);
      check("R12", 9, 1);

      // R10 flush
      alloc("R10", 10, 'h900, 2);
      alloc("R10", 11, 'h910, 2);
      flush("R10");
      check("R10", 10, 0);
      check("R10", 11, 0);

      // R8 round-robin replacement on a full table
      flush("R8");
      for (int t = 0; t < DEPTH; t++) alloc("R8", t, 'h1000 + 16 * t, 2);
      alloc("R8", 20, 'h2000, 2);
      alloc("R8", 21, 'h2010, 2);
      check("R8", 0, 0);
      check("R8", 1, 0);
      check("R8", 2, 1);
      check("R8", 20, 1);
      check("R8", 21, 1);

      // mixed traffic, compared against the reference every cycle
      flush("R8");
      for (int n = 0; n < 800; n++) begin
         step("R8", $urandom_range(0, 1), $urandom_range(0, 11), $urandom_range(0, 63),
              $urandom_range(0, 3), $urandom_range(0, 3) == 0, $urandom_range(0, 63),
              $urandom_range(0, 3), $urandom_range(0, 2) == 0, $urandom_range(0, 11),
              $urandom_range(0, 60) == 0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule